// File: doc/BRIEF.md
# Effectual-Bit Offset Term Generator

This block turns one 16-bit activation into a serial stream of power-of-two terms, one per cycle. Each term names the bit position of one nonzero digit, so a downstream shift-and-add lane spends as many cycles on the value as it has nonzero digits, not as many as it has bits. Zero bits are never emitted. The caller selects the digit form for each activation when it loads it.

In plain form, each 1 bit becomes one positive term. In signed form, the value is first recoded into non-adjacent form. A run of ones becomes a positive term above the run and a negative term at its bottom. Fewer terms then come out, and some are marked as subtractions. If that recoding would need a digit above bit 15, the activation is emitted in plain form, so every offset fits in four bits.

The activation comes in through a valid/ready handshake. Terms leave through a second valid/ready pair with offset, sign, last and zero flags. A zero activation still yields exactly one marker term. Lanes that run side by side therefore stay in step.

Top module: `effbit_term_gen`

## Requirements
- R1: After reset, `term_valid_o` is 0 and `act_ready_o` is 1.
- R2: With `mode_i`=0 (plain), one term is emitted per 1 bit of the loaded activation. The terms come in ascending offset order, each with `term_neg_o`=0.
- R3: In plain mode, activation 0x000A gives exactly two terms: offset 1, then offset 3.
- R4: With `mode_i`=1 (signed), the terms are the nonzero digits of the non-adjacent form, in ascending offset order. `term_neg_o`=1 marks a digit of −1 and 0 marks a digit of +1. The weighted sum of the terms equals the activation.
- R5: In signed mode, activation 0x0762 (six 1 bits) gives exactly four terms: +1, −5, −7, +11.
- R6: In signed mode, an activation whose non-adjacent form would need a digit at bit 16 is emitted exactly as in plain mode (for example 0xFFFF gives sixteen positive terms).
- R7: A zero activation, in either mode, gives one term with `term_zero_o`=1, `term_last_o`=1, offset 0 and sign 0. `term_zero_o` is 0 on every term of a nonzero activation.
- R8: `term_last_o` is 1 on the final term of an activation and 0 on every earlier term.
- R9: An activation is accepted when `act_valid_i` and `act_ready_o` are both 1 at a clock edge. The first term is valid in the next cycle. `act_ready_o` stays 0 from then until the cycle after the last term is consumed. A load offered while `act_ready_o` is 0 has no effect on the term stream.
- R10: While `term_valid_o` is 1 and `term_ready_i` is 0, the valid, offset, sign, last and zero outputs all hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Digit form for the loaded activation: 0 plain, 1 signed |
| act_valid_i | input | 1 | Activation offered |
| act_ready_o | output | 1 | Generator idle, can accept an activation |
| act_i | input | 16 | Activation value |
| term_valid_o | output | 1 | Term outputs are valid |
| term_ready_i | input | 1 | Consumer takes the current term |
| term_off_o | output | 4 | Bit position of the term |
| term_neg_o | output | 1 | Term is subtracted |
| term_last_o | output | 1 | Final term of this activation |
| term_zero_o | output | 1 | Marker term for a zero activation |

## Verification
The assertions assume a well-behaved producer. `mode_i` and `act_i` are only used in the cycle of the handshake, and the consumer may stall for any number of cycles. The stimulus holds `act_valid_i` high with a different value while the generator is busy, to show that such offers are ignored. Across the sweeps it drops `term_ready_i` in a pseudo-random pattern, covering stalls on first, middle and last terms. The sweeps cover every value below 1536 in both modes, plus a strided pass over the full 16-bit range. Those values include runs that touch bit 15, which exercise the plain-form fallback.

// File: rtl/effb_pkg.sv
package effb_pkg;
   typedef enum logic {
      EFFB_PLAIN  = 1'b0,
      EFFB_SIGNED = 1'b1
   } effb_mode_e;
endpackage

// File: rtl/effb_recoder.sv
module effb_recoder #(
   parameter int ACT_W       = 16,
   parameter bit IMPROVED_EN = 1'b1
) (
   input  logic             signed_mode,
   input  logic [ACT_W-1:0] act,
   output logic [ACT_W-1:0] pos_mask,
   output logic [ACT_W-1:0] neg_mask
);
   if (ACT_W < 2) begin : g_bad_width
      $error("effb_recoder: ACT_W must be at least 2");
   end

   if (IMPROVED_EN) begin : g_naf
      // floor(3x/2) = x + floor(x/2); NAF digit i is (+1) where this sum
      // has a 1 and x>>1 a 0, (-1) where x>>1 has a 1 and the sum a 0.
      logic [ACT_W-1:0] half;
      logic [ACT_W:0]   tri_half;
      logic [ACT_W:0]   naf_pos;
      logic [ACT_W-1:0] naf_neg;
      logic             spill;

      assign half     = {1'b0, act[ACT_W-1:1]};
      assign tri_half = {1'b0, act} + {1'b0, half};
      assign naf_pos  = tri_half & ~{1'b0, half};
      assign naf_neg  = half & ~tri_half[ACT_W-1:0];
      assign spill    = naf_pos[ACT_W];

      always_comb begin
         if (signed_mode && !spill) begin
            pos_mask = naf_pos[ACT_W-1:0];
            neg_mask = naf_neg;
         end else begin
            pos_mask = act;
            neg_mask = '0;
         end
      end
   end else begin : g_plain_only
      assign pos_mask = act;
      assign neg_mask = '0;
   end
endmodule

// File: rtl/effb_lsb_pick.sv
module effb_lsb_pick #(
   parameter int W  = 16,
   parameter int OW = $clog2(W)
) (
   input  logic [W-1:0]  mask,
   output logic [W-1:0]  onehot,
   output logic [OW-1:0] index
);
   if ((1 << OW) < W) begin : g_bad_ow
      $error("effb_lsb_pick: OW too narrow for W");
   end

   assign onehot = mask & (~mask + W'(1));

   always_comb begin
      index = '0;
      for (int i = 0; i < W; i++) begin
         if (onehot[i]) index = index | OW'(i);
      end
   end
endmodule

// File: rtl/effbit_term_gen.sv
module effbit_term_gen #(
   parameter int ACT_W       = 16,
   parameter int OFF_W       = $clog2(ACT_W),
   parameter bit IMPROVED_EN = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             mode_i,
   input  logic             act_valid_i,
   output logic             act_ready_o,
   input  logic [ACT_W-1:0] act_i,
   output logic             term_valid_o,
   input  logic             term_ready_i,
   output logic [OFF_W-1:0] term_off_o,
   output logic             term_neg_o,
   output logic             term_last_o,
   output logic             term_zero_o
);
   import effb_pkg::*;

   if (OFF_W != $clog2(ACT_W)) begin : g_bad_off
      $error("effbit_term_gen: OFF_W must equal clog2(ACT_W)");
   end

   effb_mode_e       mode_sel;
   logic [ACT_W-1:0] rec_pos, rec_neg;
   logic [ACT_W-1:0] pend_q, neg_q;
   logic             busy_q, zero_q;
   logic [ACT_W-1:0] pick_oh, remain;
   logic [OFF_W-1:0] pick_idx;
   logic             accept, fire, final_term;

   assign mode_sel = effb_mode_e'(mode_i);

   effb_recoder #(
      .ACT_W      (ACT_W),
      .IMPROVED_EN(IMPROVED_EN)
   ) u_recoder (
      .signed_mode(mode_sel == EFFB_SIGNED),
      .act        (act_i),
      .pos_mask   (rec_pos),
      .neg_mask   (rec_neg)
   );

   effb_lsb_pick #(
      .W (ACT_W),
      .OW(OFF_W)
   ) u_pick (
      .mask  (pend_q),
      .onehot(pick_oh),
      .index (pick_idx)
   );

   assign remain     = pend_q & ~pick_oh;
   assign final_term = zero_q | (remain == '0);
   assign accept     = act_valid_i & ~busy_q;
   assign fire       = busy_q & term_ready_i;

   assign act_ready_o  = ~busy_q;
   assign term_valid_o = busy_q;
   assign term_off_o   = busy_q ? pick_idx : '0;
   assign term_neg_o   = busy_q & |(neg_q & pick_oh);
   assign term_last_o  = busy_q & final_term;
   assign term_zero_o  = busy_q & zero_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         busy_q <= 1'b0;
         zero_q <= 1'b0;
         pend_q <= '0;
         neg_q  <= '0;
      end else if (accept) begin
         busy_q <= 1'b1;
         zero_q <= (act_i == '0);
         pend_q <= rec_pos | rec_neg;
         neg_q  <= rec_neg;
      end else if (fire) begin
         pend_q <= remain;
         if (final_term) begin
            busy_q <= 1'b0;
            zero_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/effb_term_checker.sv
module effb_term_checker #(
   parameter int OFF_W = 4
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             mode_i,
   input logic             act_valid_i,
   input logic             act_ready_o,
   input logic             term_valid_o,
   input logic             term_ready_i,
   input logic [OFF_W-1:0] term_off_o,
   input logic             term_neg_o,
   input logic             term_last_o,
   input logic             term_zero_o
);
   logic plain_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         plain_q <= 1'b1;
      else if (act_valid_i && act_ready_o) plain_q <= ~mode_i;
   end

   // R2: plain mode never emits a subtraction
   a_r2_plain_positive: assert property (@(posedge clk_i) disable iff (!rst_ni)
      term_valid_o && plain_q |-> !term_neg_o);

   // R2/R4: offsets strictly rise within one activation
   a_r4_ascending: assert property (@(posedge clk_i) disable iff (!rst_ni)
      term_valid_o && term_ready_i && !term_last_o
      |=> term_valid_o && (term_off_o > $past(term_off_o)));

   // R7: zero marker is a lone final term at offset 0
   a_r7_zero_marker: assert property (@(posedge clk_i) disable iff (!rst_ni)
      term_valid_o && term_zero_o |-> term_last_o && term_off_o == '0 && !term_neg_o);

   // R9: idle and busy never overlap
   a_r9_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({term_valid_o, act_ready_o}));

   // R9: an accepted load gives a term next cycle
   a_r9_accept_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
      act_valid_i && act_ready_o |=> term_valid_o);

   // R9: consuming the last term frees the input
   a_r9_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
      term_valid_o && term_ready_i && term_last_o |=> act_ready_o);

   // R10: stalled outputs hold
   a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      term_valid_o && !term_ready_i |=> term_valid_o && $stable(term_off_o)
         && $stable(term_neg_o) && $stable(term_last_o) && $stable(term_zero_o));
endmodule

bind effbit_term_gen effb_term_checker #(.OFF_W(OFF_W)) u_term_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .mode_i      (mode_i),
   .act_valid_i (act_valid_i),
   .act_ready_o (act_ready_o),
   .term_valid_o(term_valid_o),
   .term_ready_i(term_ready_i),
   .term_off_o  (term_off_o),
   .term_neg_o  (term_neg_o),
   .term_last_o (term_last_o),
   .term_zero_o (term_zero_o)
);

// File: tb/effbit_term_gen_test.sv
module effbit_term_gen_test;
   localparam int CLK_PERIOD = 10;
   localparam int WDOG_LIMIT = 190000;

   logic        clk_i = 1'b0;
   logic        rst_ni = 1'b0;
   logic        mode_i = 1'b0;
   logic        act_valid_i = 1'b0;
   logic        act_ready_o;
   logic [15:0] act_i = '0;
   logic        term_valid_o;
   logic        term_ready_i = 1'b0;
   logic [3:0]  term_off_o;
   logic        term_neg_o;
   logic        term_last_o;
   logic        term_zero_o;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;
   logic [15:0] lfsr = 16'hACE1;

   effbit_term_gen uut (
      .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i),
      .act_valid_i(act_valid_i), .act_ready_o(act_ready_o), .act_i(act_i),
      .term_valid_o(term_valid_o), .term_ready_i(term_ready_i),
      .term_off_o(term_off_o), .term_neg_o(term_neg_o),
      .term_last_o(term_last_o), .term_zero_o(term_zero_o)
   );

   always #(CLK_PERIOD/2) clk_i = ~clk_i;

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   always @(posedge clk_i) begin
      cyc <= cyc + 1;
      if (cyc == WDOG_LIMIT) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: run did not complete, actual cycles=%0d expected<%0d",
                  cyc, WDOG_LIMIT);
         finish_run();
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int actual, input int expected);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, actual, expected);
      end
   endtask

   // serial NAF model, plain fallback when a digit above bit 15 is needed
   task automatic model(input logic [15:0] a, input bit sgn,
                        output logic [15:0] pm, output logic [15:0] nm, output bit spill);
      int carry = 0;
      pm = '0; nm = '0; spill = 0;
      for (int i = 0; i <= 16; i++) begin
         int x   = ((i < 16) ? int'(a[i]) : 0) + carry;
         int nxt = (i < 15) ? int'(a[i+1]) : 0;
         if (x == 2) carry = 1;
         else if (x == 1) begin
            if (nxt == 1) begin
               if (i < 16) nm[i] = 1'b1;
               carry = 1;
            end else begin
               if (i < 16) pm[i] = 1'b1; else spill = 1;
               carry = 0;
            end
         end else carry = 0;
      end
      if (!sgn || spill) begin
         pm = a; nm = '0;
      end
   endtask

   task automatic run_one(input logic [15:0] a, input bit sgn, input string tag);
      logic [15:0] pm, nm, all;
      bit spill, done, rdy, stalled;
      int offs[16];
      bit negs[16];
      int n = 0, k = 0;
      string req;
      model(a, sgn, pm, nm, spill);
      all = pm | nm;
      for (int i = 0; i < 16; i++) begin
         if (all[i]) begin
            offs[n] = i; negs[n] = nm[i]; n++;
         end
      end
      if (tag != "") req = tag;
      else if (a == 0) req = "R7";
      else if (sgn && spill) req = "R6";
      else req = sgn ? "R4" : "R2";

      @(negedge clk_i);
      check(act_ready_o == 1'b1, "R9", "ready before load", int'(act_ready_o), 1);
      act_valid_i = 1'b1; act_i = a; mode_i = sgn;
      @(posedge clk_i);
      @(negedge clk_i);
      // keep offering a different value while busy: it must be ignored (R9)
      act_valid_i = lfsr[3];
      act_i = ~a; mode_i = ~sgn;
      done = 0; stalled = 0;
      while (!done) begin
         if (k != 0 || stalled) @(negedge clk_i);
         check(term_valid_o == 1'b1, "R9", "term valid", int'(term_valid_o), 1);
         check(act_ready_o == 1'b0, "R9", "busy ready low", int'(act_ready_o), 0);
         if (n == 0) begin
            check(term_zero_o && term_last_o && term_off_o == 0 && !term_neg_o,
                  "R7", "zero marker flags",
                  {term_zero_o, term_last_o, term_neg_o, term_off_o}, 32'h60);
         end else begin
            check(term_off_o == offs[k], stalled ? "R10" : req, "offset",
                  int'(term_off_o), offs[k]);
            check(term_neg_o == negs[k], stalled ? "R10" : req, "sign",
                  int'(term_neg_o), int'(negs[k]));
            check(term_last_o == (k == n-1), "R8", "last flag",
                  int'(term_last_o), int'(k == n-1));
            check(term_zero_o == 1'b0, "R7", "zero flag on nonzero",
                  int'(term_zero_o), 0);
         end
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         rdy = lfsr[0] | lfsr[1];
         term_ready_i = rdy;
         if (rdy && term_last_o) act_valid_i = 1'b0;
         @(posedge clk_i);
         if (rdy) begin
            stalled = 0;
            if (k >= n-1) done = 1; else k++;
         end else stalled = 1;
      end
      @(negedge clk_i);
      term_ready_i = 1'b0;
      check(act_ready_o == 1'b1 && term_valid_o == 1'b0, "R9", "release after last",
            {act_ready_o, term_valid_o}, 2);
   endtask

   initial begin
      repeat (3) @(posedge clk_i);
      @(negedge clk_i);
      rst_ni = 1'b1;
      @(negedge clk_i);
      check(term_valid_o == 1'b0, "R1", "valid after reset", int'(term_valid_o), 0);
      check(act_ready_o == 1'b1, "R1", "ready after reset", int'(act_ready_o), 1);

      run_one(16'h000A, 1'b0, "R3");
      run_one(16'h0762, 1'b1, "R5");
      run_one(16'hFFFF, 1'b1, "R6");
      run_one(16'hC000, 1'b1, "R6");
      run_one(16'h0000, 1'b0, "R7");
      run_one(16'h0000, 1'b1, "R7");
      run_one(16'h8000, 1'b1, "");

      for (int v = 0; v < 1536; v++) run_one(16'(v), 1'b0, "");
      for (int v = 0; v < 1536; v++) run_one(16'(v), 1'b1, "");
      for (int v = 0; v < 65536; v += 211) begin
         run_one(16'(v), 1'b0, "");
         run_one(16'(v ^ 16'hF000), 1'b1, "");
      end
      finish_run();
   end
endmodule